// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This block keeps a short queue of upcoming instruction bytes ahead of a downstream decoder. It reads 16-bit words from memory while the decoder removes bytes one at a time, so fetching and decoding overlap. Each read address is a 20-bit physical address. It is formed from a 16-bit code segment value shifted left by four bits, added to a 16-bit fetch offset. The offset advances inside its segment and never carries into the segment value.

A redirect input carries a new segment:offset target for jumps and interrupts. A redirect empties the queue and restarts fetching at the target. Data from a read that was still in flight when the redirect came is thrown away. The memory side is a request/grant port followed by a response strobe, with at most one read outstanding. The decoder side is a byte-wide valid/ready port.

Top module: `fetch_queue_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `byte_vld_o` and `rd_req_o` are low. The first read issued after reset uses segment `RESET_SEG` and offset `RESET_OFF`.
- R2: `rd_addr_o` equals segment*16 + offset, taken modulo 2^20. For example, FFFFh:FFF8h gives 0FFE8h.
- R3: A read is requested only when no read is outstanding and at least 2 of the queue's byte slots are free. A consumer that is stalled with a full queue sees no new request.
- R4: For a read at an even offset, the low byte (data bits 7:0) is queued first and then the high byte (bits 15:8). The offset advances by 2.
- R5: For a read at an odd offset, only the high byte (bits 15:8) is queued, and the offset advances by 1. A stalled queue started at an odd offset holds 5 bytes.
- R6: The offset wraps from FFFFh to 0000h and the segment is left unchanged.
- R7: The consumer port presents the oldest byte with `byte_vld_o` high. That byte is removed on a cycle where `byte_vld_o` and `byte_rdy_i` are both high. `byte_vld_o` is low when the queue is empty.
- R8: A redirect empties the queue, so `byte_vld_o` is low in the next cycle. A redirect takes priority over a pop or a read response in the same cycle. Bytes that follow come from the new target.
- R9: If a read is requested or outstanding when a redirect arrives, its response data is discarded.
- R10: The queue never holds more than `QDEPTH` (6) bytes. `rd_addr_o` holds steady while `rd_req_o` waits for `rd_gnt_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| redirect_i | input | 1 | Flush the queue and restart fetching at the target |
| redirect_seg_i | input | 16 | Target segment value |
| redirect_off_i | input | 16 | Target offset |
| rd_req_o | output | 1 | Word read request |
| rd_addr_o | output | 20 | Physical byte address of the read |
| rd_gnt_i | input | 1 | Memory accepts the request this cycle |
| rd_rsp_i | input | 1 | Read data valid; arrives at least one cycle after the grant |
| rd_data_i | input | 16 | Word containing the addressed byte; the even address is in bits 7:0 |
| byte_vld_o | output | 1 | Oldest queued byte is present |
| byte_o | output | 8 | Oldest queued byte |
| byte_rdy_i | input | 1 | Consumer takes the byte |

## Verification
The assertions check the following on every cycle:
- the occupancy bound, and that each push has room;
- the single outstanding read, and that free space exists whenever a request starts;
- that the request address holds steady until it is granted;
- that the offset steps by exactly one or two with wrap-around;
- that the queue is empty after each redirect.

Some behaviour shows only in the bench's scenarios:
- the byte content and order seen by the consumer, checked against an arithmetic memory image walked offset by offset;
- the fill levels of 6 and 5 bytes when stalled at even and odd starts;
- the address overflow past 20 bits;
- the loss of stale data when a redirect collides with a pending grant or with a response.

// File: rtl/fq_pkg.sv
package fq_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 2 * BYTE_W;
  typedef logic [BYTE_W-1:0] fq_byte_t;
endpackage

// File: rtl/fq_byte_queue.sv
module fq_byte_queue
  import fq_pkg::*;
#(
  parameter int unsigned DEPTH = 6,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush_i,
  input  logic [1:0]       push_n_i,
  input  fq_byte_t         push_b0_i,
  input  fq_byte_t         push_b1_i,
  input  logic             pop_i,
  output fq_byte_t         head_o,
  output logic             vld_o,
  output logic [CNT_W-1:0] count_o
);
  fq_byte_t         slot_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q, wr_nxt;
  logic [CNT_W-1:0] count_q;
  logic             pop_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wr_nxt  = ptr_inc(wr_q);
  assign pop_ok  = pop_i && (count_q != '0);
  assign head_o  = slot_q[rd_q];
  assign vld_o   = (count_q != '0);
  assign count_o = count_q;

  // data storage without reset
  always_ff @(posedge clk) begin
    if (!flush_i) begin
      if (push_n_i != 2'd0) slot_q[wr_q]   <= push_b0_i;
      if (push_n_i == 2'd2) slot_q[wr_nxt] <= push_b1_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush_i) begin
      rd_q    <= '0;
      wr_q    <= '0;
      count_q <= '0;
    end else begin
      if (pop_ok) rd_q <= ptr_inc(rd_q);
      case (push_n_i)
        2'd1:    wr_q <= wr_nxt;
        2'd2:    wr_q <= ptr_inc(wr_nxt);
        default: wr_q <= wr_q;
      endcase
      count_q <= count_q + CNT_W'(push_n_i) - CNT_W'(pop_ok);
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count_q <= CNT_W'(DEPTH));

  // R3
  push_room_chk: assert property (@(posedge clk) disable iff (rst)
    !flush_i |-> (int'(count_q) + int'(push_n_i) - int'(pop_ok)) <= int'(DEPTH));

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (count_q == '0));
endmodule

// File: rtl/fq_addr_gen.sv
module fq_addr_gen #(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned OFF_W = 16,
  parameter int unsigned SHIFT = 4,
  parameter logic [SEG_W-1:0] RESET_SEG = '0,
  parameter logic [OFF_W-1:0] RESET_OFF = '0,
  localparam int unsigned ADDR_W = SEG_W + SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [SEG_W-1:0]  load_seg_i,
  input  logic [OFF_W-1:0]  load_off_i,
  input  logic              adv_i,
  input  logic              adv_two_i,
  output logic [ADDR_W-1:0] phys_o,
  output logic              odd_o
);
  logic [SEG_W-1:0] seg_q;
  logic [OFF_W-1:0] off_q;
  logic [OFF_W-1:0] step;

  assign step   = adv_two_i ? OFF_W'(2) : OFF_W'(1);
  assign phys_o = (ADDR_W'(seg_q) << SHIFT) + ADDR_W'(off_q);
  assign odd_o  = off_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q <= RESET_SEG;
      off_q <= RESET_OFF;
    end else if (load_i) begin
      seg_q <= load_seg_i;
      off_q <= load_off_i;
    end else if (adv_i) begin
      off_q <= off_q + step;
    end
  end

  // R4 R5 R6
  off_step_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !load_i) |=> (off_q == $past(off_q) + $past(step)) && $stable(seg_q));
endmodule

// File: rtl/fetch_queue_unit.sv
module fetch_queue_unit
  import fq_pkg::*;
#(
  parameter int unsigned QDEPTH = 6,
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned SHIFT  = 4,
  parameter logic [SEG_W-1:0] RESET_SEG = '0,
  parameter logic [OFF_W-1:0] RESET_OFF = '0,
  localparam int unsigned ADDR_W = SEG_W + SHIFT,
  localparam int unsigned CNT_W  = $clog2(QDEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              redirect_i,
  input  logic [SEG_W-1:0]  redirect_seg_i,
  input  logic [OFF_W-1:0]  redirect_off_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_gnt_i,
  input  logic              rd_rsp_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  input  logic              byte_rdy_i
);
  logic              req_q, wait_q, stale_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] phys;
  logic              odd;
  logic [CNT_W-1:0]  q_count;
  logic              accept, rsp_take, can_issue, push_en;
  logic [1:0]        push_n;
  fq_byte_t          b0, b1;

  assign accept    = req_q && rd_gnt_i;
  assign rsp_take  = rd_rsp_i && wait_q;
  assign can_issue = !req_q && !wait_q && !redirect_i && (q_count <= CNT_W'(QDEPTH - 2));
  assign push_en   = rsp_take && !stale_q && !redirect_i;
  assign push_n    = push_en ? (odd ? 2'd1 : 2'd2) : 2'd0;
  assign b0        = odd ? rd_data_i[WORD_W-1:BYTE_W] : rd_data_i[BYTE_W-1:0];
  assign b1        = rd_data_i[WORD_W-1:BYTE_W];

  fq_addr_gen #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT),
    .RESET_SEG(RESET_SEG), .RESET_OFF(RESET_OFF)
  ) u_addr (
    .clk(clk), .rst(rst),
    .load_i(redirect_i), .load_seg_i(redirect_seg_i), .load_off_i(redirect_off_i),
    .adv_i(push_en), .adv_two_i(!odd),
    .phys_o(phys), .odd_o(odd)
  );

  fq_byte_queue #(.DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst(rst), .flush_i(redirect_i),
    .push_n_i(push_n), .push_b0_i(b0), .push_b1_i(b1),
    .pop_i(byte_rdy_i), .head_o(byte_o), .vld_o(byte_vld_o), .count_o(q_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= 1'b0;
      wait_q  <= 1'b0;
      stale_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      if (accept) begin
        req_q  <= 1'b0;
        wait_q <= 1'b1;
      end
      if (rsp_take) wait_q <= 1'b0;
      if (can_issue) begin
        req_q  <= 1'b1;
        addr_q <= phys;
      end
      if (rsp_take) stale_q <= 1'b0;
      else if (redirect_i && (req_q || wait_q)) stale_q <= 1'b1;
    end
  end

  assign rd_req_o  = req_q;
  assign rd_addr_o = addr_q;

  // R3
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_req_o && wait_q));

  // R3
  issue_room_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_req_o) |-> (q_count <= CNT_W'(QDEPTH - 2)));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && !rd_gnt_i) |=> (rd_req_o && $stable(rd_addr_o)));

  // R8
  redirect_empty_chk: assert property (@(posedge clk) disable iff (rst)
    redirect_i |=> !byte_vld_o);
endmodule

// File: tb/fetch_queue_unit_test.sv
module fetch_queue_unit_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        redirect = 1'b0;
  logic [15:0] redirect_seg = '0, redirect_off = '0;
  logic        rd_req, rd_gnt, rd_rsp;
  logic [19:0] rd_addr;
  logic [15:0] rd_data;
  logic        byte_vld, byte_rdy = 1'b0;
  logic [7:0]  byte_q;

  int checks = 0, errors = 0;
  int gnt_mode = 0;
  logic [15:0] glfsr = 16'hACE1;
  logic [15:0] slfsr = 16'h1D2B;
  logic [15:0] exp_seg, exp_off;
  logic        prev_redir = 1'b0;
  int          pops = 0, reqs = 0;
  string       tag = "R4";

  always #(PERIOD/2) clk = ~clk;

  fetch_queue_unit #(.RESET_SEG(16'hFFFF), .RESET_OFF(16'h0000)) uut (
    .clk(clk), .rst(rst),
    .redirect_i(redirect), .redirect_seg_i(redirect_seg), .redirect_off_i(redirect_off),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_gnt_i(rd_gnt),
    .rd_rsp_i(rd_rsp), .rd_data_i(rd_data),
    .byte_vld_o(byte_vld), .byte_o(byte_q), .byte_rdy_i(byte_rdy)
  );

  function automatic logic [7:0] mem_byte(input logic [19:0] p);
    return p[7:0] + 8'(p[15:8] * 3) + 8'(p[19:16] * 7);
  endfunction

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return ({4'b0, s} << 4) + {4'b0, o};
  endfunction

  // memory: grant pattern and one-cycle response
  assign rd_gnt = (gnt_mode == 0) || (gnt_mode == 1 && glfsr[0]);
  always @(posedge clk) begin
    glfsr <= {glfsr[14:0], glfsr[15] ^ glfsr[13] ^ glfsr[12] ^ glfsr[10]};
    if (rst) rd_rsp <= 1'b0;
    else begin
      rd_rsp  <= rd_req && rd_gnt;
      rd_data <= {mem_byte(rd_addr | 20'h1), mem_byte(rd_addr & ~20'h1)};
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic step(input logic rdy, input logic redir,
                      input logic [15:0] s, input logic [15:0] o);
    logic [7:0] e;
    @(negedge clk);
    byte_rdy = rdy;
    redirect = redir;
    redirect_seg = s;
    redirect_off = o;
    #1;
    if (rd_req) reqs++;
    if (prev_redir) check(!byte_vld, "R8", "valid after redirect", byte_vld, 0);
    if (byte_vld && byte_rdy && !redirect) begin
      e = mem_byte(phys(exp_seg, exp_off));
      check(byte_q == e, tag, "byte", byte_q, e);
      exp_off = exp_off + 16'd1;
      pops++;
    end
    if (redirect) begin
      exp_seg = s;
      exp_off = o;
    end
    prev_redir = redir;
  endtask

  task automatic run(input int n, input logic rdy);
    for (int i = 0; i < n; i++) step(rdy, 1'b0, '0, '0);
  endtask

  task automatic stall_drain(input logic [15:0] s, input logic [15:0] o,
                             input int expect_n, input string req);
    step(1'b0, 1'b1, s, o);
    run(20, 1'b0);
    reqs = 0;
    run(20, 1'b0);
    check(reqs == 0, "R3", "requests while full", reqs, 0);
    gnt_mode = 2;
    pops = 0;
    run(20, 1'b1);
    check(pops == expect_n, req, "bytes held when stalled", pops, expect_n);
    gnt_mode = 0;
    run(20, 1'b1);
  endtask

  initial begin
    #(PERIOD * 190000);
    errors++;
    $display("FAIL watchdog: cycles got %0d expected below %0d", 190000, 190000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit seen;
    exp_seg = 16'hFFFF;
    exp_off = 16'h0000;
    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      check(!byte_vld && !rd_req, "R1", "vld/req in reset", {byte_vld, rd_req}, 0);
    end
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(!byte_vld && !rd_req, "R1", "vld/req first cycle", {byte_vld, rd_req}, 0);
    seen = 0;
    for (int i = 0; i < 3 && !seen; i++) begin
      @(negedge clk); #1;
      if (rd_req) begin
        seen = 1;
        check(rd_addr == 20'hFFFF0, "R1", "first read address", rd_addr, 20'hFFFF0);
      end
    end
    check(seen, "R1", "first request seen", seen, 1);
    // R4 even start from reset target
    tag = "R4";
    run(40, 1'b1);
    // R5 odd start
    tag = "R5";
    step(1'b1, 1'b1, 16'h1234, 16'h0101);
    run(40, 1'b1);
    // R6 offset wrap within segment
    tag = "R6";
    step(1'b1, 1'b1, 16'h2000, 16'hFFFB);
    run(40, 1'b1);
    step(1'b1, 1'b1, 16'h2001, 16'hFFFA);
    run(40, 1'b1);
    // R2 20-bit address overflow
    tag = "R2";
    step(1'b1, 1'b1, 16'hFFFF, 16'hFFF8);
    run(40, 1'b1);
    // R10 / R5 stalled fill levels
    tag = "R10";
    stall_drain(16'h0040, 16'h0010, 6, "R10");
    tag = "R5";
    stall_drain(16'h0040, 16'h0011, 5, "R5");
    // R8 redirect lands on the response cycle
    tag = "R8";
    step(1'b0, 1'b1, 16'h5000, 16'h0000);
    run(2, 1'b0);
    step(1'b0, 1'b1, 16'h6000, 16'h0023);
    run(40, 1'b1);
    // R9 redirect while request waits for grant
    tag = "R9";
    gnt_mode = 2;
    step(1'b1, 1'b1, 16'h3000, 16'h0000);
    run(4, 1'b1);
    step(1'b1, 1'b1, 16'h4000, 16'h0007);
    gnt_mode = 0;
    run(40, 1'b1);
    // R7 / R9 long mixed run
    tag = "R7";
    gnt_mode = 1;
    for (int i = 0; i < 20000; i++) begin
      slfsr = {slfsr[14:0], slfsr[15] ^ slfsr[13] ^ slfsr[12] ^ slfsr[10]};
      if (slfsr[5:0] == 6'd0)
        step(slfsr[7], 1'b1, {slfsr[3:0], slfsr[15:4]}, {slfsr[11:0], slfsr[15:12]});
      else
        step(slfsr[8] | slfsr[9], 1'b0, '0, '0);
    end
    gnt_mode = 0;
    run(20, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule